// File: doc/BRIEF.md
# Banked IRQ/FIQ Interrupt Controller

This block gathers 96 level-sensitive interrupt lines into three 32-bit banks and drives two request lines toward a processor. The first is a normal request. The second is a fast request for sources that software has routed to it. Each bank has a mask word, a route word that chooses the fast request, an enable word and a sticky fast-pending word. A vector word gives the byte offset of the lowest-numbered active source. Three plain control words hold a base address, a protect value and an NMI value.

Software reaches the controller through a small synchronous register port. The port has a byte address, a write strobe with write data, and a read strobe. Read data comes back one cycle after the read strobe. The input levels are captured into the pending banks on every clock. The request outputs and the vector are derived combinationally from the captured levels and the stored control words. A change on a line or a register write therefore shows up at the outputs right after the next clock edge.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, every mapped word reads 0, and `irq_o` and `fiq_o` are low.
- R2: The pending bit for source `i` sits in bank `i/32` at bit `i%32`. It equals the level on `irq_lines[i]` that was sampled at the previous clock edge. The pending banks are at byte offsets 0x10, 0x14 and 0x18.
- R3: `irq_o` is high exactly when some pending bit has a mask bit of 0. A mask bit of 1 blocks its source. The mask banks are at 0x50, 0x54 and 0x58.
- R4: `fiq_o` is high exactly when some pending, unmasked bit also has its route bit set to 1. The route banks are at 0x30, 0x34 and 0x38.
- R5: The vector word at offset 0x00 reads 4 × the lowest index among pending, unmasked sources. Banks are searched in ascending order. When no source is active, the vector reads 0.
- R6: Writes to the pending banks and to the vector word have no effect.
- R7: A fast-pending bit (banks at 0x20, 0x24 and 0x28) is set by a pending, unmasked, routed source. It stays set after the source goes away. Writing a 1 to the bit clears it, and writing a 0 leaves it unchanged. If the source is still active, setting wins over clearing.
- R8: A write to the base word at 0x04 stores the data with bits [1:0] forced to 0.
- R9: The enable banks at 0x40, 0x44 and 0x48 read back what was written and have no effect on `irq_o`, `fiq_o` or the vector.
- R10: The protect word at 0x08 and the NMI word at 0x0C store and return all 32 bits.
- R11: Inside a banked group, address bits [3:2] select the bank. The following offsets are unmapped: any offset with bits [1:0] not zero, bank field 3, and any offset from 0x60 up to 0x3FF. Unmapped offsets read 0, and writes to them change nothing.
- R12: `rdata` is registered. It changes only on the clock edge that samples `rd_en` high, and it holds its value while `rd_en` is low. A change on a line reaches `irq_o` on the next edge, not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | 96 | Level-sensitive interrupt sources |
| addr | input | 10 | Byte address within the 0x400 window |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench drives each of the 96 sources alone and checks the vector and the pending bit. A swapped bank or a bit position off by one would return the wrong offset for some index. It also pairs sources in different banks and masks the lower one. A vector search that scanned banks in the wrong order, or ignored the mask, would then report the wrong source. It writes to the pending banks, to bank field 3, to misaligned offsets and to offsets past the map. A loose decoder would then corrupt a neighbouring bank. It holds a routed source active while clearing its fast-pending bit. A design where the clear beat the set would drop a live fast request.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Width of one bank word and of the register port data.
    localparam int unsigned WORD_W     = 32;
    // Address bits [3:2] pick a bank inside a banked group.
    localparam int unsigned BANK_SEL_W = 2;
    // Address bits below this are inside the mapped part of the window.
    localparam int unsigned MAP_W      = 7;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_VECTOR,
        REG_BASE,
        REG_PROTECT,
        REG_NMI,
        REG_PEND,
        REG_FPEND,
        REG_ROUTE,
        REG_ENABLE,
        REG_MASK
    } reg_kind_e;

    // Group codes taken from address bits [6:4].
    localparam logic [2:0] GRP_SINGLE = 3'd0;
    localparam logic [2:0] GRP_PEND   = 3'd1;
    localparam logic [2:0] GRP_FPEND  = 3'd2;
    localparam logic [2:0] GRP_ROUTE  = 3'd3;
    localparam logic [2:0] GRP_ENABLE = 3'd4;
    localparam logic [2:0] GRP_MASK   = 3'd5;

endpackage

// File: rtl/irqc_addr_dec.sv
module irqc_addr_dec
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned NUM_BANKS = 3
) (
    input  logic [ADDR_W-1:0]     addr,
    output reg_kind_e             kind,
    output logic [BANK_SEL_W-1:0] bank
);

    logic in_map;
    logic bank_ok;

    always_comb begin
        bank    = addr[3:2];
        in_map  = ((addr >> MAP_W) == '0) && (addr[1:0] == 2'b00);
        bank_ok = 32'(addr[3:2]) < NUM_BANKS;
        kind    = REG_NONE;
        if (in_map) begin
            unique case (addr[6:4])
                GRP_SINGLE: begin
                    unique case (addr[3:2])
                        2'd0:    kind = REG_VECTOR;
                        2'd1:    kind = REG_BASE;
                        2'd2:    kind = REG_PROTECT;
                        default: kind = REG_NMI;
                    endcase
                end
                GRP_PEND:   if (bank_ok) kind = REG_PEND;
                GRP_FPEND:  if (bank_ok) kind = REG_FPEND;
                GRP_ROUTE:  if (bank_ok) kind = REG_ROUTE;
                GRP_ENABLE: if (bank_ok) kind = REG_ENABLE;
                GRP_MASK:   if (bank_ok) kind = REG_MASK;
                default:    kind = REG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/irqc_lowbit.sv
module irqc_lowbit #(
    parameter int unsigned W     = 32,
    parameter int unsigned IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so that the lowest set bit is the last one written.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irqc_vector.sv
module irqc_vector #(
    parameter int unsigned NUM_BANKS = 3,
    parameter int unsigned W         = 32,
    parameter int unsigned VEC_W     = 9
) (
    input  logic [NUM_BANKS-1:0][W-1:0] active,
    output logic [VEC_W-1:0]            vec_o
);

    localparam int unsigned IDX_W = $clog2(W);

    logic [NUM_BANKS-1:0]            found;
    logic [NUM_BANKS-1:0][IDX_W-1:0] idx;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irqc_lowbit #(.W(W), .IDX_W(IDX_W)) u_low (
            .vec   (active[b]),
            .found (found[b]),
            .idx   (idx[b])
        );
    end

    // Descending walk: the lowest bank that has a hit wins.
    always_comb begin
        vec_o = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (found[b]) vec_o = (VEC_W'(b * W) + VEC_W'(idx[b])) << 2;
        end
    end

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 3,
    parameter int unsigned ADDR_W    = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BANKS*WORD_W-1:0]   irq_lines,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          wr_en,
    input  logic [WORD_W-1:0]             wdata,
    input  logic                          rd_en,
    output logic [WORD_W-1:0]             rdata,
    output logic                          irq_o,
    output logic                          fiq_o
);

    localparam int unsigned W       = WORD_W;
    localparam int unsigned NUM_SRC = NUM_BANKS * W;
    localparam int unsigned VEC_W   = $clog2(NUM_SRC * 4);

    typedef logic [NUM_BANKS-1:0][W-1:0] banks_t;

    typedef struct packed {
        banks_t        pend;
        banks_t        fpend;
        banks_t        route;
        banks_t        enable;
        banks_t        mask;
        logic [W-1:0]  base;
        logic [W-1:0]  protect;
        logic [W-1:0]  nmi;
        logic [W-1:0]  rdata;
    } state_t;

    state_t state_d, state_q;

    reg_kind_e             kind;
    logic [BANK_SEL_W-1:0] bank;
    banks_t                active;
    banks_t                fast_active;
    banks_t                clr;
    logic [VEC_W-1:0]      vec;
    logic [W-1:0]          rd_val;

    irqc_addr_dec #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
        .addr (addr),
        .kind (kind),
        .bank (bank)
    );

    assign active      = state_q.pend & ~state_q.mask;
    assign fast_active = active & state_q.route;

    irqc_vector #(.NUM_BANKS(NUM_BANKS), .W(W), .VEC_W(VEC_W)) u_vec (
        .active (active),
        .vec_o  (vec)
    );

    assign irq_o = |active;
    assign fiq_o = |fast_active;
    assign rdata = state_q.rdata;

    always_comb begin
        unique case (kind)
            REG_VECTOR:  rd_val = W'(vec);
            REG_BASE:    rd_val = state_q.base;
            REG_PROTECT: rd_val = state_q.protect;
            REG_NMI:     rd_val = state_q.nmi;
            REG_PEND:    rd_val = state_q.pend[bank];
            REG_FPEND:   rd_val = state_q.fpend[bank];
            REG_ROUTE:   rd_val = state_q.route[bank];
            REG_ENABLE:  rd_val = state_q.enable[bank];
            REG_MASK:    rd_val = state_q.mask[bank];
            default:     rd_val = '0;
        endcase
    end

    always_comb begin
        state_d      = state_q;
        state_d.pend = irq_lines;
        clr          = '0;
        if (wr_en) begin
            unique case (kind)
                REG_BASE:    state_d.base          = wdata & ~W'(3);
                REG_PROTECT: state_d.protect       = wdata;
                REG_NMI:     state_d.nmi           = wdata;
                REG_FPEND:   clr[bank]             = wdata;
                REG_ROUTE:   state_d.route[bank]   = wdata;
                REG_ENABLE:  state_d.enable[bank]  = wdata;
                REG_MASK:    state_d.mask[bank]    = wdata;
                default:     ;
            endcase
        end
        state_d.fpend = (state_q.fpend & ~clr) | fast_active;
        if (rd_en) state_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned NUM_SRC = 96,
    parameter int unsigned ADDR_W  = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_lines,
    input logic [ADDR_W-1:0]  addr,
    input logic               rd_en,
    input logic [31:0]        rdata,
    input logic               irq_o,
    input logic               fiq_o
);

    // R2: no line high at the previous edge means nothing is pending
    a_r2_idle_lines_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_lines) == '0) |-> (!irq_o && !fiq_o));

    // R3: a request needs a line that was high at the previous edge
    a_r3_irq_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|irq_lines));

    // R4: a fast request is a subset of the normal request
    a_r4_fiq_within_irq: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> irq_o);

    // R5: a vector read is word aligned and inside the source range
    a_r5_vector_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(0)) |=> (rdata[1:0] == 2'b00 && rdata < 32'(NUM_SRC * 4)));

    // R8: a base read never shows the low two bits
    a_r8_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(4)) |=> (rdata[1:0] == 2'b00));

    // R11: reads past the mapped area return zero
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr >> 7) != '0) |=> (rdata == 32'd0));

    // R12: read data holds while no read is issued
    a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind banked_irq_ctrl irqc_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_irqc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .addr      (addr),
    .rd_en     (rd_en),
    .rdata     (rdata),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
);

// File: tb/banked_irq_ctrl_tb_top.sv
module banked_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 3;
    localparam int NSRC       = NB * 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] lines = '0;
    logic [9:0]      addr = '0;
    logic            wr_en = 1'b0;
    logic [31:0]     wdata = '0;
    logic            rd_en = 1'b0;
    logic [31:0]     rdata;
    logic            irq_o;
    logic            fiq_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    banked_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(10)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (lines),
        .addr      (addr),
        .wr_en     (wr_en),
        .wdata     (wdata),
        .rd_en     (rd_en),
        .rdata     (rdata),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic drive(input logic [NSRC-1:0] v);
        @(negedge clk);
        lines = v;
        @(negedge clk);
    endtask

    task automatic rd_check(input logic [9:0] a, input logic [31:0] exp, input string req);
        logic [31:0] got;
        rd(a, got);
        check(got == exp, req, got, exp);
    endtask

    function automatic logic [31:0] lowest_vec(input logic [NSRC-1:0] act);
        for (int i = 0; i < NSRC; i++) if (act[i]) return 32'(i * 4);
        return 32'd0;
    endfunction

    task automatic report;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        report();
        $finish;
    end

    initial begin
        logic [31:0]     got;
        logic [NSRC-1:0] v;
        logic [NSRC-1:0] msk;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(irq_o == 1'b0, "R1 irq", 32'(irq_o), 0);
        check(fiq_o == 1'b0, "R1 fiq", 32'(fiq_o), 0);
        for (int o = 0; o < 16; o++) rd_check(10'(o * 4), 0, "R1 single");
        for (int g = 1; g <= 5; g++)
            for (int b = 0; b < NB; b++) rd_check(10'(g * 16 + b * 4), 0, "R1 bank");

        // R10: full-width words
        wr(10'h08, 32'hA5A5_5A5A);
        wr(10'h0C, 32'h1234_5678);
        rd_check(10'h08, 32'hA5A5_5A5A, "R10 protect");
        rd_check(10'h0C, 32'h1234_5678, "R10 nmi");

        // R8: base alignment
        wr(10'h04, 32'hFFFF_FFFF);
        rd_check(10'h04, 32'hFFFF_FFFC, "R8 base ones");
        wr(10'h04, 32'h0000_1237);
        rd_check(10'h04, 32'h0000_1234, "R8 base value");

        // R11: bank selection in every writable group
        for (int g = 3; g <= 5; g++)
            for (int b = 0; b < NB; b++) wr(10'(g * 16 + b * 4), 32'(g * 32'h0101_0000 + b * 32'h11 + 1));
        for (int g = 3; g <= 5; g++)
            for (int b = 0; b < NB; b++) rd_check(10'(g * 16 + b * 4), 32'(g * 32'h0101_0000 + b * 32'h11 + 1), "R11 bank");

        // R11: unmapped offsets read 0 and do not disturb neighbours
        wr(10'h5C, 32'hFFFF_FFFF);
        wr(10'h3C, 32'hFFFF_FFFF);
        wr(10'h31, 32'hFFFF_FFFF);
        wr(10'h60, 32'hFFFF_FFFF);
        wr(10'h3FC, 32'hFFFF_FFFF);
        rd_check(10'h5C, 0, "R11 bank3 read");
        rd_check(10'h31, 0, "R11 misaligned read");
        rd_check(10'h60, 0, "R11 past map read");
        rd_check(10'h3FC, 0, "R11 window end read");
        for (int g = 3; g <= 5; g++)
            for (int b = 0; b < NB; b++) rd_check(10'(g * 16 + b * 4), 32'(g * 32'h0101_0000 + b * 32'h11 + 1), "R11 no side effect");

        // clear route/mask, leave enable at all ones
        for (int b = 0; b < NB; b++) begin
            wr(10'(16'h30 + b * 4), 0);
            wr(10'(16'h50 + b * 4), 0);
            wr(10'(16'h40 + b * 4), 32'hFFFF_FFFF);
        end

        // R9: enable does not create a request
        drive('0);
        check(irq_o == 1'b0, "R9 enable idle", 32'(irq_o), 0);

        // R2/R3/R5: single-source sweep
        for (int i = 0; i < NSRC; i++) begin
            v = '0; v[i] = 1'b1;
            drive(v);
            check(irq_o == 1'b1, "R3 single irq", 32'(irq_o), 1);
            check(fiq_o == 1'b0, "R4 unrouted fiq", 32'(fiq_o), 0);
            rd_check(10'h00, 32'(i * 4), "R5 single vector");
            rd_check(10'(16'h10 + (i / 32) * 4), 32'(1) << (i % 32), "R2 pending bit");
        end

        // R9: enable cleared has no effect either
        for (int b = 0; b < NB; b++) wr(10'(16'h40 + b * 4), 0);
        v = '0; v[40] = 1'b1;
        drive(v);
        check(irq_o == 1'b1, "R9 enable zero", 32'(irq_o), 1);
        rd_check(10'h00, 32'd160, "R9 vector");

        // R5/R3: pairs, masking the lower one, then both
        for (int i = 0; i < NSRC; i += 7) begin
            int j;
            j = (i + 33) % NSRC;
            v = '0; v[i] = 1'b1; v[j] = 1'b1;
            drive(v);
            rd_check(10'h00, lowest_vec(v), "R5 pair vector");
            msk = '0; msk[i < j ? i : j] = 1'b1;
            for (int b = 0; b < NB; b++) wr(10'(16'h50 + b * 4), msk[b*32 +: 32]);
            rd_check(10'h00, lowest_vec(v & ~msk), "R5 masked low");
            check(irq_o == 1'b1, "R3 one unmasked", 32'(irq_o), 1);
            msk[i] = 1'b1; msk[j] = 1'b1;
            for (int b = 0; b < NB; b++) wr(10'(16'h50 + b * 4), msk[b*32 +: 32]);
            check(irq_o == 1'b0, "R3 all masked", 32'(irq_o), 0);
            rd_check(10'h00, 0, "R5 none active");
            for (int b = 0; b < NB; b++) wr(10'(16'h50 + b * 4), 0);
        end

        // R4/R7: routing source 37 (bank 1 bit 5) to the fast request
        drive('0);
        wr(10'h34, 32'h0000_0020);
        v = '0; v[36] = 1'b1;
        drive(v);
        check(fiq_o == 1'b0, "R4 neighbour not routed", 32'(fiq_o), 0);
        check(irq_o == 1'b1, "R3 neighbour irq", 32'(irq_o), 1);
        rd_check(10'h24, 0, "R7 no fast pending");
        v = '0; v[37] = 1'b1;
        drive(v);
        check(fiq_o == 1'b1, "R4 routed fiq", 32'(fiq_o), 1);
        wr(10'h54, 32'h0000_0020);
        check(fiq_o == 1'b0, "R4 masked fiq", 32'(fiq_o), 0);
        check(irq_o == 1'b0, "R3 masked irq", 32'(irq_o), 0);
        wr(10'h54, 0);
        rd_check(10'h24, 32'h0000_0020, "R7 captured");
        wr(10'h24, 32'h0000_0020);
        rd_check(10'h24, 32'h0000_0020, "R7 set wins while active");
        drive('0);
        rd_check(10'h24, 32'h0000_0020, "R7 sticky");
        wr(10'h24, 32'hFFFF_FFDF);
        rd_check(10'h24, 32'h0000_0020, "R7 zero bit keeps");
        wr(10'h24, 32'h0000_0020);
        rd_check(10'h24, 0, "R7 cleared");

        // R6: pending and vector are not writable
        v = '0; v[3] = 1'b1; v[70] = 1'b1;
        drive(v);
        wr(10'h10, 32'hFFFF_FFFF);
        wr(10'h18, 32'h0000_0000);
        wr(10'h00, 32'h0000_0100);
        rd_check(10'h10, 32'h0000_0008, "R6 pend bank0");
        rd_check(10'h18, 32'h0000_0040, "R6 pend bank2");
        rd_check(10'h00, 32'd12, "R6 vector");

        // R12: output waits for the edge, read data is registered
        drive('0);
        @(negedge clk);
        lines[50] = 1'b1;
        #1;
        check(irq_o == 1'b0, "R12 before edge", 32'(irq_o), 0);
        @(negedge clk);
        check(irq_o == 1'b1, "R12 after edge", 32'(irq_o), 1);
        rd(10'h08, got);
        addr = 10'h0C; rd_en = 1'b1;
        #1;
        check(rdata == 32'hA5A5_5A5A, "R12 read latency", rdata, 32'hA5A5_5A5A);
        @(negedge clk);
        rd_en = 1'b0;
        check(rdata == 32'h1234_5678, "R12 read data", rdata, 32'h1234_5678);
        addr = 10'h08;
        @(negedge clk);
        check(rdata == 32'h1234_5678, "R12 holds", rdata, 32'h1234_5678);

        report();
        $finish;
    end

endmodule